// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block collects the interrupt conditions of a UART channel and reduces them to one interrupt line and one 4-bit identification code. Five sources feed it: a receiver line status error, received data available, a receive timeout, the transmit holding register going empty, and a modem status change. Four enable bits mask them. Data available and timeout share one enable bit and one priority level. At any time the code names only the enabled pending source of highest priority. Lower sources stay hidden until software has serviced it.

The line status error, the timeout, the holding-register-empty event and the modem change arrive as one-cycle event pulses. Each one sets a sticky pending flag, and the matching service action clears that flag. Data available is a level that the receiver drives. It is reported as long as it holds. The CPU writes the enable register through a plain write strobe. Register reads reach the block as one-cycle strobes. The block needs these strobes only to clear the conditions that each read services. No data stream passes through the block, so all pins are plain control and status signals.

Top module: `uart_irq_ident`

## Requirements
- R1: The enable register takes `en_wdata[3:0]` on `en_wr`. Bit 0 enables data available and timeout, bit 1 enables holding-register empty, bit 2 enables line status and bit 3 enables modem status. `en_rdata[3:0]` returns the stored bits and `en_rdata[7:4]` always reads 0. Reset clears every bit.
- R2: A line status error that is pending and enabled shows code 0110 in `id_code[3:0]` above every other source. A `lsr_rd` strobe clears it.
- R3: While `rx_avail` is high, enabled and no line status is reported, the code is 0100. The source follows the level and has no latch.
- R4: A pending, enabled receive timeout shows code 1100. Within level 2 it takes precedence over data available. An `rbr_rd` strobe clears it.
- R5: A pending, enabled holding-register-empty event shows code 0010 when no level 1 or level 2 source is reported. Two actions clear it: an `id_rd` strobe while the code is 0010, or a `thr_wr` strobe.
- R6: A pending, enabled modem status change shows code 0000 only when nothing higher is reported. An `msr_rd` strobe clears it.
- R7: With no enabled source pending, the code is 0001 and `irq` is low. Otherwise `irq` is high.
- R8: A source whose enable bit is 0 is never reported. Its pending flag is kept, so setting the enable bit later reports it.
- R9: An event pulse sets its flag at the next clock edge, and the code shows it one cycle after the pulse. When a set and a clear reach the same flag in one cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_rdata | output | 8 | Enable register contents, upper nibble zero |
| ls_evt | input | 1 | Receiver line status error event pulse |
| rx_avail | input | 1 | Received data available level |
| tmo_evt | input | 1 | Receive timeout event pulse |
| thre_evt | input | 1 | Holding register became empty, pulse |
| ms_evt | input | 1 | Modem status change event pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive data read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| id_rd | input | 1 | Identification register read strobe |
| id_code | output | 4 | Identification code of highest pending enabled source |
| irq | output | 1 | Interrupt request, active high |

## Verification
A flag that is lost, stuck or wrongly cleared changes `id_code` at the first cycle it becomes the top enabled source. The bench compares the code and `irq` against a model on every cycle, so such a fault shows within one cycle of that point. A priority or masking fault shows as a wrong code whenever two sources overlap. Random traffic that toggles the enables produces such overlaps often. Directed cases cover the same-cycle set and clear race and clearing by an identification read.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W   = 8;
  localparam int EN_BITS = 4;
  localparam int CODE_W  = 4;
  localparam int NFLAG   = 4;

  // sticky flag slots
  localparam int F_LS  = 0;
  localparam int F_TMO = 1;
  localparam int F_TX  = 2;
  localparam int F_MS  = 3;

  // enable bit positions
  localparam int E_RX = 0;
  localparam int E_TX = 1;
  localparam int E_LS = 2;
  localparam int E_MS = 3;

  typedef enum logic [CODE_W-1:0] {
    ID_LS   = 4'b0110,
    ID_RXD  = 4'b0100,
    ID_TMO  = 4'b1100,
    ID_TX   = 4'b0010,
    ID_MS   = 4'b0000,
    ID_NONE = 4'b0001
  } id_code_e;
endpackage

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
(
  input  logic [NFLAG-1:0]   pend_i,
  input  logic               rx_avail_i,
  input  logic [EN_BITS-1:0] en_i,
  output id_code_e           code_o
);
  always_comb begin
    if (pend_i[F_LS] && en_i[E_LS])        code_o = ID_LS;
    else if (pend_i[F_TMO] && en_i[E_RX])  code_o = ID_TMO;
    else if (rx_avail_i && en_i[E_RX])     code_o = ID_RXD;
    else if (pend_i[F_TX] && en_i[E_TX])   code_o = ID_TX;
    else if (pend_i[F_MS] && en_i[E_MS])   code_o = ID_MS;
    else                                   code_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en_wr,
  input  logic [7:0]  en_wdata,
  output logic [7:0]  en_rdata,
  input  logic        ls_evt,
  input  logic        rx_avail,
  input  logic        tmo_evt,
  input  logic        thre_evt,
  input  logic        ms_evt,
  input  logic        lsr_rd,
  input  logic        rbr_rd,
  input  logic        thr_wr,
  input  logic        msr_rd,
  input  logic        id_rd,
  output logic [3:0]  id_code,
  output logic        irq
);
  logic [EN_BITS-1:0] en_q;
  logic [NFLAG-1:0]   set_v, clr_v, pend_v;
  id_code_e           code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_wr) en_q <= en_wdata[EN_BITS-1:0];
  end

  assign en_rdata = {{(REG_W-EN_BITS){1'b0}}, en_q};

  always_comb begin
    set_v        = '0;
    clr_v        = '0;
    set_v[F_LS]  = ls_evt;
    clr_v[F_LS]  = lsr_rd;
    set_v[F_TMO] = tmo_evt;
    clr_v[F_TMO] = rbr_rd;
    set_v[F_TX]  = thre_evt;
    clr_v[F_TX]  = thr_wr | (id_rd && code == ID_TX);
    set_v[F_MS]  = ms_evt;
    clr_v[F_MS]  = msr_rd;
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    irq_sticky_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set_i(set_v[g]),
      .clr_i(clr_v[g]),
      .q_o  (pend_v[g])
    );
  end

  irq_prio_enc u_enc (
    .pend_i    (pend_v),
    .rx_avail_i(rx_avail),
    .en_i      (en_q),
    .code_o    (code)
  );

  assign id_code = code;
  assign irq     = (code != ID_NONE);
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_wr,
  input logic [7:0] en_rdata,
  input logic       ls_evt,
  input logic       ms_evt,
  input logic       thre_evt,
  input logic       msr_rd,
  input logic       id_rd,
  input logic [3:0] id_code,
  input logic       irq
);
  assert_en_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_rdata[7:4] == 4'b0000);

  assert_ls_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_evt && en_rdata[2] && !en_wr) |=> id_code == 4'b0110);

  assert_tx_id_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (id_rd && id_code == 4'b0010 && !thre_evt) |=> id_code != 4'b0010);

  assert_ms_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_rd && !ms_evt) |=> id_code != 4'b0000);

  assert_irq_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (id_code != 4'b0001));

  assert_all_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_rdata[3:0] == 4'b0000) |-> !irq);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_wr   (en_wr),
  .en_rdata(en_rdata),
  .ls_evt  (ls_evt),
  .ms_evt  (ms_evt),
  .thre_evt(thre_evt),
  .msr_rd  (msr_rd),
  .id_rd   (id_rd),
  .id_code (id_code),
  .irq     (irq)
);

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk = 0;
  logic rst_n = 0;
  logic en_wr = 0;
  logic [7:0] en_wdata = 0;
  logic [7:0] en_rdata;
  logic ls_evt = 0, rx_avail = 0, tmo_evt = 0, thre_evt = 0, ms_evt = 0;
  logic lsr_rd = 0, rbr_rd = 0, thr_wr = 0, msr_rd = 0, id_rd = 0;
  logic [3:0] id_code;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  bit m_ls, m_tmo, m_tx, m_ms;
  logic [3:0] m_en;

  always #2.5 clk = ~clk;

  uart_irq_ident dut (.*);

  function automatic logic [3:0] ref_code();
    if (m_ls && m_en[2])       return 4'b0110;
    if (m_tmo && m_en[0])      return 4'b1100;
    if (rx_avail && m_en[0])   return 4'b0100;
    if (m_tx && m_en[1])       return 4'b0010;
    if (m_ms && m_en[3])       return 4'b0000;
    return 4'b0001;
  endfunction

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'b0110: return "R2";
      4'b0100: return "R3";
      4'b1100: return "R4";
      4'b0010: return "R5";
      4'b0000: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clr_in();
    en_wr = 0; ls_evt = 0; tmo_evt = 0; thre_evt = 0; ms_evt = 0;
    lsr_rd = 0; rbr_rd = 0; thr_wr = 0; msr_rd = 0; id_rd = 0;
  endtask

  // inputs already driven at negedge; advance model over one edge and check
  task automatic step(input string req);
    logic [3:0] pre = ref_code();
    logic [3:0] exp;
    if (ls_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
    if (tmo_evt) m_tmo = 1; else if (rbr_rd) m_tmo = 0;
    if (thre_evt) m_tx = 1; else if (thr_wr || (id_rd && pre == 4'b0010)) m_tx = 0;
    if (ms_evt) m_ms = 1; else if (msr_rd) m_ms = 0;
    if (en_wr) m_en = en_wdata[3:0];
    @(posedge clk);
    @(negedge clk);
    clr_in();
    #0;
    exp = ref_code();
    chk(req == "" ? tag_of(exp) : req, {4'h0, id_code}, {4'h0, exp});
    chk("R7", {7'h0, irq}, {7'h0, exp != 4'b0001});
    chk("R1", en_rdata, {4'h0, m_en});
  endtask

  task automatic wr_en(input logic [7:0] v);
    en_wr = 1; en_wdata = v; step("R1");
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    m_ls = 0; m_tmo = 0; m_tx = 0; m_ms = 0; m_en = 0;
    repeat (3) @(negedge clk);
    // reset state
    chk("R7", {4'h0, id_code}, 8'h01);
    chk("R1", en_rdata, 8'h00);
    rst_n = 1;
    @(negedge clk);

    // R1 upper bits read zero
    wr_en(8'hF5);
    wr_en(8'h00);

    // R8: masked events pend but are not reported
    ls_evt = 1; thre_evt = 1; ms_evt = 1; step("R8");
    wr_en(8'h08); // modem only
    wr_en(8'h0A); // tx over modem
    wr_en(8'h0F); // line status tops all (R2)
    rx_avail = 1;
    tmo_evt = 1; step("R4");
    lsr_rd = 1; step("R2");      // timeout now top
    rbr_rd = 1; step("R4");      // timeout clears, data available shows
    rx_avail = 0; step("R3");    // level gone, tx shows
    // R9: set and clear same cycle, set wins
    thre_evt = 1; thr_wr = 1; step("R9");
    id_rd = 1; step("R5");       // read while tx reported clears it
    chk("R5", {4'h0, id_code}, 8'h00);
    msr_rd = 1; ms_evt = 1; step("R9");
    msr_rd = 1; step("R6");
    chk("R7", {7'h0, irq}, 8'h00);
    // id read while a different source is reported leaves tx pending
    thre_evt = 1; ls_evt = 1; step("R2");
    id_rd = 1; step("R5");
    lsr_rd = 1; step("R5");
    thr_wr = 1; step("R5");

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      ls_evt   = ($urandom % 16) == 0;
      tmo_evt  = ($urandom % 16) == 0;
      thre_evt = ($urandom % 8) == 0;
      ms_evt   = ($urandom % 12) == 0;
      lsr_rd   = ($urandom % 6) == 0;
      rbr_rd   = ($urandom % 6) == 0;
      thr_wr   = ($urandom % 10) == 0;
      msr_rd   = ($urandom % 8) == 0;
      id_rd    = ($urandom % 4) == 0;
      if (($urandom % 20) == 0) rx_avail = ~rx_avail;
      if (($urandom % 40) == 0) begin en_wr = 1; en_wdata = 8'($urandom); end
      step("");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule